// File: doc/BRIEF.md
# Byte-Wide Fuse Array Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse macro. A host presents a start byte address and a byte count together with a one-cycle start pulse. The sequencer then drives the macro's control word through a fixed timed pattern: read-mode entry, then per byte an address phase, a strobe phase and a capture, and finally a standby word. Each captured byte appears on a byte output that is qualified by a single-cycle valid flag. A done pulse closes the request.

Guard intervals are measured in clock cycles. A parameter gives the number of cycles in one microsecond, and every guard interval lasts that many cycles, or one cycle if the parameter is zero. A build-time parameter selects between two control-pin layouts. The standard layout uses load, strobe, chip-select-bar and program-enable-bar. The alternative layout uses a read-enable and an address-enable pair.

Top module: `efuse_rd_seq`

## Requirements
- R1: After reset, busy_o, done_o and rd_valid_o are low. fuse_ctrl_o is the standby word: 16'h0009 in the standard layout and 16'h0000 in the alternative layout.
- R2: In the standard layout, fuse_ctrl_o bit 0 is chip-select-bar, bit 1 is strobe, bit 2 is load and bit 3 is program-enable-bar. The 10-bit byte address sits in bits [15:6]. While a byte is being read, the control word is 16'h000C with the address in [15:6], and strobe is added during the strobe phase.
- R3: On accepting a request, the standard layout drives the entry word 16'h000C (load and program-enable-bar high, chip-select-bar low, address zero) for one guard interval before the first address is applied.
- R4: Each byte takes the following steps. One cycle with the address field cleared. One guard interval with the address applied. One guard interval with strobe high. One capture cycle with strobe still high. One guard interval with strobe low. With D the guard length and N > 0 the byte count, busy_o is high for exactly D + N*(3D+2) + 1 cycles.
- R5: Every byte sampled from the macro data input during the capture cycle is presented on rd_byte_o, with rd_valid_o high for exactly one cycle, in address order.
- R6: The address advances by one after each byte and wraps from 1023 to 0.
- R7: After the last byte, the standby word is written for one cycle (16'h0009 in the standard layout). busy_o falls in the next cycle, and done_o pulses for one cycle in that same cycle.
- R8: A start with a byte count of zero produces a done_o pulse in the next cycle. busy_o never rises and fuse_ctrl_o does not change.
- R9: A start pulse while busy_o is high is ignored. The running request completes with its own address and count, and no further request follows.
- R10: In the alternative layout, bit 2 is read-enable and bit 1 is address-enable, and address-enable takes the place of strobe. The entry word is 16'h0004. At exit only read-enable is cleared, so the word left in place carries just the last byte address in [15:6].
- R11: The guard length D equals the cycles-per-microsecond parameter, or one cycle when that parameter is zero.

Behaviour by layout:

| Quantity | Standard layout | Alternative layout |
|---|---|---|
| Bit 0 | chip-select-bar | unused |
| Bit 1 | strobe | address-enable |
| Bit 2 | load | read-enable |
| Bit 3 | program-enable-bar | unused |
| Entry word | 16'h000C | 16'h0004 |
| Standby word | 16'h0009 | last address in [15:6] |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse, taken only while idle |
| start_addr_i | input | ADDR_W | First fuse byte address |
| byte_count_i | input | ADDR_W+1 | Number of bytes to read |
| busy_o | output | 1 | High while a request is in progress |
| done_o | output | 1 | One-cycle pulse marking the end of a request |
| fuse_ctrl_o | output | CTRL_W | Control word to the fuse macro |
| fuse_dout_i | input | DATA_W | Data output of the fuse macro |
| rd_byte_o | output | DATA_W | Captured fuse byte |
| rd_valid_o | output | 1 | Qualifies rd_byte_o for one cycle |

## Verification
The assertions assume three things about the host:
- it raises start_i as a pulse rather than a level;
- it holds the address and count steady in the cycle the pulse is taken;
- it never needs a strobe edge to coincide with an address change.

The stimulus keeps to these assumptions. It drives start for a single cycle at the falling clock edge. It changes inputs mid-request only to show that they are ignored. The fuse model answers only while the strobe or address-enable line is high, so a byte captured outside that phase reads as zero and shows up as a mismatch.

// File: rtl/efrd_pkg.sv
// Shared definitions for the fuse read sequencer.
// Assumes: control-word bit positions are fixed by the fuse macro pinout.
package efrd_pkg;

    // Sequencer phases; the order only matters for readability.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_ACLR,
        ST_ASET,
        ST_STRB,
        ST_CAPT,
        ST_STBL,
        ST_STBY
    } seq_state_e;

    // Standard layout pin positions (decoded by the macro).
    localparam int STD_CSB_BIT    = 0;
    localparam int STD_STROBE_BIT = 1;
    localparam int STD_LOAD_BIT   = 2;
    localparam int STD_PGMB_BIT   = 3;

    // Alternative layout pin positions.
    localparam int ALT_AEN_BIT    = 1;
    localparam int ALT_REN_BIT    = 2;

endpackage

// File: rtl/efrd_delay.sv
// Guard-interval timer. Loading starts an interval of DLY cycles, counting
// the load cycle's successor as the first; expired_o is high in the last.
// Assumes: load_i is only pulsed on a phase transition.
module efrd_delay #(
    parameter int CYC_PER_US = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int DLY = (CYC_PER_US < 1) ? 1 : CYC_PER_US;
    localparam int CW  = (DLY > 1) ? $clog2(DLY) : 1;

    logic [CW-1:0] cnt_q;

    // Down-counter: reload on a new interval, otherwise count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CW'(DLY - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/efrd_fsm.sv
// Phase controller: accepts requests, walks the per-byte phases, tracks the
// current address and remaining count, and raises capture/done pulses.
// Assumes: the timer restarts whenever tmr_load_o is high.
module efrd_fsm
    import efrd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W:0]   count_i,
    input  logic              tmr_expired_i,
    output logic              tmr_load_o,
    output seq_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              capture_o,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [ADDR_W:0]   left_q, left_d;
    logic              done_q, done_d;

    // Next-phase decision and timer restarts.
    always_comb begin
        state_d    = state_q;
        addr_d     = addr_q;
        left_d     = left_q;
        done_d     = 1'b0;
        tmr_load_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (count_i == '0) begin
                        done_d = 1'b1;
                    end else begin
                        state_d    = ST_ENTER;
                        addr_d     = addr_i;
                        left_d     = count_i;
                        tmr_load_o = 1'b1;
                    end
                end
            end
            ST_ENTER: begin
                if (tmr_expired_i) state_d = ST_ACLR;
            end
            ST_ACLR: begin
                state_d    = ST_ASET;
                tmr_load_o = 1'b1;
            end
            ST_ASET: begin
                if (tmr_expired_i) begin
                    state_d    = ST_STRB;
                    tmr_load_o = 1'b1;
                end
            end
            ST_STRB: begin
                if (tmr_expired_i) state_d = ST_CAPT;
            end
            ST_CAPT: begin
                state_d    = ST_STBL;
                tmr_load_o = 1'b1;
            end
            ST_STBL: begin
                if (tmr_expired_i) begin
                    if (left_q == {{ADDR_W{1'b0}}, 1'b1}) begin
                        state_d = ST_STBY;
                    end else begin
                        state_d = ST_ACLR;
                        addr_d  = addr_q + 1'b1;
                        left_d  = left_q - 1'b1;
                    end
                end
            end
            ST_STBY: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase, address, count and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            left_q  <= left_d;
            done_q  <= done_d;
        end
    end

    assign state_o   = state_q;
    assign addr_o    = addr_q;
    assign capture_o = (state_q == ST_CAPT);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;

endmodule

// File: rtl/efrd_pin_map.sv
// Maps the registered phase and address onto the macro control word for the
// selected pin layout. Purely combinational from registered state.
// Assumes: CTRL_W >= ADDR_LSB + ADDR_W and CTRL_W >= 4.
module efrd_pin_map
    import efrd_pkg::*;
#(
    parameter int ALT_PINS = 0,
    parameter int ADDR_W   = 10,
    parameter int ADDR_LSB = 6,
    parameter int CTRL_W   = 16
) (
    input  seq_state_e        state_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CTRL_W-1:0] ctrl_o
);
    generate
        if (ALT_PINS == 0) begin : g_std
            // Standard layout: load/strobe with active-low select and program enable.
            always_comb begin
                ctrl_o = '0;
                unique case (state_i)
                    ST_ENTER, ST_ACLR: begin
                        ctrl_o[STD_LOAD_BIT] = 1'b1;
                        ctrl_o[STD_PGMB_BIT] = 1'b1;
                    end
                    ST_ASET, ST_STBL: begin
                        ctrl_o[STD_LOAD_BIT] = 1'b1;
                        ctrl_o[STD_PGMB_BIT] = 1'b1;
                        ctrl_o[ADDR_LSB +: ADDR_W] = addr_i;
                    end
                    ST_STRB, ST_CAPT: begin
                        ctrl_o[STD_LOAD_BIT]   = 1'b1;
                        ctrl_o[STD_PGMB_BIT]   = 1'b1;
                        ctrl_o[STD_STROBE_BIT] = 1'b1;
                        ctrl_o[ADDR_LSB +: ADDR_W] = addr_i;
                    end
                    default: begin
                        ctrl_o[STD_CSB_BIT]  = 1'b1;
                        ctrl_o[STD_PGMB_BIT] = 1'b1;
                    end
                endcase
            end
        end else begin : g_alt
            // Alternative layout: read-enable held, address-enable as strobe.
            always_comb begin
                ctrl_o = '0;
                unique case (state_i)
                    ST_ENTER, ST_ACLR: begin
                        ctrl_o[ALT_REN_BIT] = 1'b1;
                    end
                    ST_ASET, ST_STBL: begin
                        ctrl_o[ALT_REN_BIT] = 1'b1;
                        ctrl_o[ADDR_LSB +: ADDR_W] = addr_i;
                    end
                    ST_STRB, ST_CAPT: begin
                        ctrl_o[ALT_REN_BIT] = 1'b1;
                        ctrl_o[ALT_AEN_BIT] = 1'b1;
                        ctrl_o[ADDR_LSB +: ADDR_W] = addr_i;
                    end
                    default: begin
                        ctrl_o[ADDR_LSB +: ADDR_W] = addr_i;
                    end
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/efuse_rd_seq.sv
// Top of the fuse read sequencer: phase controller, guard timer, pin mapper
// and the output byte register.
// Assumes: the macro data output is valid while strobe/address-enable is high.
module efuse_rd_seq
    import efrd_pkg::*;
#(
    parameter int CYC_PER_US = 4,
    parameter int ALT_PINS   = 0,
    parameter int ADDR_W     = 10,
    parameter int ADDR_LSB   = 6,
    parameter int CTRL_W     = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W:0]   byte_count_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CTRL_W-1:0] fuse_ctrl_o,
    input  logic [DATA_W-1:0] fuse_dout_i,
    output logic [DATA_W-1:0] rd_byte_o,
    output logic              rd_valid_o
);
    seq_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic              tmr_load;
    logic              tmr_expired;
    logic              capture;
    logic [DATA_W-1:0] byte_q;
    logic              valid_q;

    efrd_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .addr_i        (start_addr_i),
        .count_i       (byte_count_i),
        .tmr_expired_i (tmr_expired),
        .tmr_load_o    (tmr_load),
        .state_o       (state),
        .addr_o        (cur_addr),
        .capture_o     (capture),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    efrd_delay #(
        .CYC_PER_US (CYC_PER_US)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    efrd_pin_map #(
        .ALT_PINS (ALT_PINS),
        .ADDR_W   (ADDR_W),
        .ADDR_LSB (ADDR_LSB),
        .CTRL_W   (CTRL_W)
    ) u_map (
        .state_i (state),
        .addr_i  (cur_addr),
        .ctrl_o  (fuse_ctrl_o)
    );

    // Capture the macro byte during the capture phase and flag it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= capture;
            if (capture) byte_q <= fuse_dout_i;
        end
    end

    assign rd_byte_o  = byte_q;
    assign rd_valid_o = valid_q;

endmodule

// File: rtl/efuse_rd_seq_chk.sv
// Protocol checker for the fuse read sequencer, bound to every instance.
// Assumes: start is a pulse and inputs are steady when it is taken.
module efuse_rd_seq_chk #(
    parameter int ALT_PINS = 0,
    parameter int ADDR_W   = 10,
    parameter int ADDR_LSB = 6,
    parameter int CTRL_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              valid,
    input logic [CTRL_W-1:0] ctrl
);
    // R5: a byte flag never lasts two cycles.
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R5: bytes only appear inside a request.
    a_r5_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);

    // R7: done is never raised while still busy.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: the end of a request is always marked by done.
    a_r7_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: the address is settled before the strobe edge.
    a_r4_addr_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[1]) |-> $stable(ctrl[ADDR_LSB +: ADDR_W]));

    generate
        if (ALT_PINS == 0) begin : g_std
            // R1: the standard layout idles in the standby word.
            a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
                !busy |-> (ctrl == CTRL_W'(9)));
        end else begin : g_alt
            // R10: the alternative layout idles with both enables low.
            a_r10_idle_enables: assert property (@(posedge clk) disable iff (!rst_n)
                !busy |-> (ctrl[2:0] == 3'b000));
        end
    endgenerate

endmodule

bind efuse_rd_seq efuse_rd_seq_chk #(
    .ALT_PINS (ALT_PINS),
    .ADDR_W   (ADDR_W),
    .ADDR_LSB (ADDR_LSB),
    .CTRL_W   (CTRL_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy_o),
    .done  (done_o),
    .valid (rd_valid_o),
    .ctrl  (fuse_ctrl_o)
);

// File: tb/efuse_fuse_model.sv
// Behavioural fuse array for the bench: 1024 bytes filled from SEED, data
// presented only while the layout's read strobe is active, else zero.
module efuse_fuse_model #(
    parameter int ALT_PINS = 0,
    parameter logic [7:0] SEED = 8'h5A
) (
    input  logic [15:0] ctrl_i,
    output logic [7:0]  dout_o
);
    logic [7:0] mem [1024];
    logic       rd_en;

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'(i * 29) ^ 8'(i >> 2) ^ SEED;
        end
    end

    assign rd_en  = (ALT_PINS != 0) ? (ctrl_i[2] & ctrl_i[1])
                                    : (ctrl_i[2] & ctrl_i[1] & ~ctrl_i[0]);
    assign dout_o = rd_en ? mem[ctrl_i[15:6]] : 8'h00;

endmodule

// File: tb/efuse_rd_seq_tb_top.sv
// Bench: drives a standard-layout and an alternative-layout sequencer with
// the same requests and checks bytes, timing and control words.
module efuse_rd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STD_CYC    = 3;
    localparam int ALT_CYC    = 0;
    localparam int STD_DLY    = 3;
    localparam int ALT_DLY    = 1;
    localparam logic [7:0] SEED = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  addr_in = '0;
    logic [10:0] cnt_in = '0;

    logic        std_busy, std_done, std_vld, alt_busy, alt_done, alt_vld;
    logic [15:0] std_ctrl, alt_ctrl;
    logic [7:0]  std_dout, alt_dout, std_byte, alt_byte;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    efuse_fuse_model #(.ALT_PINS(0), .SEED(SEED)) std_fuse_i (.ctrl_i(std_ctrl), .dout_o(std_dout));
    efuse_fuse_model #(.ALT_PINS(1), .SEED(SEED)) alt_fuse_i (.ctrl_i(alt_ctrl), .dout_o(alt_dout));

    efuse_rd_seq #(.CYC_PER_US(STD_CYC), .ALT_PINS(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(addr_in),
        .byte_count_i(cnt_in), .busy_o(std_busy), .done_o(std_done),
        .fuse_ctrl_o(std_ctrl), .fuse_dout_i(std_dout),
        .rd_byte_o(std_byte), .rd_valid_o(std_vld));

    efuse_rd_seq #(.CYC_PER_US(ALT_CYC), .ALT_PINS(1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(addr_in),
        .byte_count_i(cnt_in), .busy_o(alt_busy), .done_o(alt_done),
        .fuse_ctrl_o(alt_ctrl), .fuse_dout_i(alt_dout),
        .rd_byte_o(alt_byte), .rd_valid_o(alt_vld));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int a);
        return 8'(a * 29) ^ 8'(a >> 2) ^ SEED;
    endfunction

    function automatic logic [15:0] addr_word(input int a);
        return 16'(a % 1024) << 6;
    endfunction

    // One request on both instances; optionally a second start mid-run.
    task automatic run_op(input int a, input int n, input bit intrude);
        int s_idx = 0, a_idx = 0, s_busy = 0, a_busy = 0, guard = 0;
        bit s_done = 0, a_done = 0, s_seen = 0, a_seen = 0;
        logic [15:0] s_prev, a_prev;
        int s_exp_busy, a_exp_busy;
        s_prev = std_ctrl;
        a_prev = alt_ctrl;
        @(negedge clk);
        start = 1'b1; addr_in = 10'(a); cnt_in = 11'(n);
        @(negedge clk);
        start = 1'b0;
        while (!(s_done && a_done) && guard < 5000) begin
            guard++;
            if (intrude && guard == 6) begin
                start = 1'b1; addr_in = 10'd0; cnt_in = 11'd7;
            end else begin
                start = 1'b0;
            end
            if (!s_done) begin
                if (std_busy) begin
                    if (!s_seen) chk(std_ctrl == 16'h000C, "R3", "std entry word", std_ctrl, 16'h000C);
                    s_seen = 1; s_busy++;
                end
                if (std_vld) begin
                    chk(std_byte == exp_byte((a + s_idx) % 1024), "R5", "std byte", std_byte, exp_byte((a + s_idx) % 1024));
                    chk(std_ctrl[15:6] == 10'((a + s_idx) % 1024), "R6", "std address", std_ctrl[15:6], (a + s_idx) % 1024);
                    if (s_idx == 0)
                        chk(std_ctrl == (16'h000C | addr_word(a)), "R2", "std byte word", std_ctrl, 16'h000C | addr_word(a));
                    s_idx++;
                end
                if (std_done) begin
                    s_done = 1;
                    chk(!std_busy, "R7", "std busy at done", std_busy, 0);
                end
            end
            if (!a_done) begin
                if (alt_busy) begin
                    if (!a_seen) chk(alt_ctrl == 16'h0004, "R10", "alt entry word", alt_ctrl, 16'h0004);
                    a_seen = 1; a_busy++;
                end
                if (alt_vld) begin
                    chk(alt_byte == exp_byte((a + a_idx) % 1024), "R5", "alt byte", alt_byte, exp_byte((a + a_idx) % 1024));
                    chk(alt_ctrl == (16'h0004 | addr_word(a + a_idx)), "R10", "alt byte word", alt_ctrl, 16'h0004 | addr_word(a + a_idx));
                    a_idx++;
                end
                if (alt_done) begin
                    a_done = 1;
                    chk(!alt_busy, "R7", "alt busy at done", alt_busy, 0);
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(guard < 5000, "R7", "request completion", guard, 0);
        chk(s_idx == n, "R9", "std byte count", s_idx, n);
        chk(a_idx == n, "R9", "alt byte count", a_idx, n);
        s_exp_busy = (n == 0) ? 0 : STD_DLY + n * (3 * STD_DLY + 2) + 1;
        a_exp_busy = (n == 0) ? 0 : ALT_DLY + n * (3 * ALT_DLY + 2) + 1;
        chk(s_busy == s_exp_busy, "R4", "std busy cycles", s_busy, s_exp_busy);
        chk(a_busy == a_exp_busy, "R11", "alt busy cycles", a_busy, a_exp_busy);
        if (n > 0) begin
            chk(std_ctrl == 16'h0009, "R7", "std standby", std_ctrl, 16'h0009);
            chk(alt_ctrl == addr_word(a + n - 1), "R10", "alt exit word", alt_ctrl, addr_word(a + n - 1));
        end else begin
            chk(std_ctrl == s_prev, "R8", "std ctrl untouched", std_ctrl, s_prev);
            chk(alt_ctrl == a_prev, "R8", "alt ctrl untouched", alt_ctrl, a_prev);
        end
        if (intrude) begin
            repeat (3) @(negedge clk);
            chk(!std_busy && !alt_busy, "R9", "no follow-on request", std_busy | alt_busy, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!std_busy && !alt_busy, "R1", "busy after reset", std_busy | alt_busy, 0);
        chk(!std_done && !alt_done, "R1", "done after reset", std_done | alt_done, 0);
        chk(!std_vld && !alt_vld, "R1", "valid after reset", std_vld | alt_vld, 0);
        chk(std_ctrl == 16'h0009, "R1", "std reset word", std_ctrl, 16'h0009);
        chk(alt_ctrl == 16'h0000, "R1", "alt reset word", alt_ctrl, 16'h0000);
        run_op(0, 1, 0);
        run_op(5, 4, 0);
        run_op(1020, 8, 0);   // R6 wrap past 1023
        run_op(1023, 2, 0);
        run_op(511, 0, 0);    // R8 zero count
        run_op(100, 5, 1);    // R9 start while busy
        for (int c = 1; c <= 6; c++) run_op(1021, c, 0);
        for (int k = 0; k < 16; k++) run_op(k * 64 + 63, 2, 0);
        run_op(300, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule